// File: doc/BRIEF.md
# Debug-Link Security Unlock Gate

This block runs the security handshake on a single-wire debug link. After a power-on reset it takes exactly eight bytes from the host, one at a time, through a byte-wide receive strobe. Each byte is sent back to the host as an echo after a fixed number of bit-time ticks. Each byte is also compared with the matching byte of an eight-byte stored code. A mismatch in any byte is remembered, and the outcome is decided only when the eighth byte has been echoed. The block then waits one more bit time and sends a break request, which tells the host that commands may follow. At that point it sets either a sticky unlock flag or a sticky failed flag.

While the block is not unlocked, it replaces every read of protected memory with a fixed invalid byte. Any instruction fetch from that memory produces an illegal-address reset request. A failed attempt can only be retried after a power-on reset. The ordinary warm reset leaves the handshake progress and its outcome alone. A mass-erase command sets every stored code byte to 0xFF. The erased code survives power-on reset, so a host can then unlock the device with eight 0xFF bytes.

Top module: `sec_gate`

## Requirements
- R1: After power-on reset (`por_n` low), `tx_valid`, `tx_break` and `illegal_rst` are 0 and `status` is 8'h00. `rd_data` equals the parameter `BAD` (default 8'h5A).
- R2: The block echoes each of the first eight received bytes. `tx_valid` pulses high for one cycle, with `tx_data` equal to the received byte, in the cycle after the clock edge that samples the second `bit_tick` following the `rx_valid` cycle. A `bit_tick` that arrives in the same cycle as `rx_valid` is not counted.
- R3: A byte that arrives while an echo is still pending is ignored. It is not echoed and does not count as one of the eight.
- R4: No break is sent before the eighth echo. `tx_break` pulses for one cycle in the cycle after the edge that samples the first `bit_tick` following the eighth echo. It is never high together with `tx_valid`.
- R5: If all eight bytes match, `status` becomes 8'h40 (bit 6 = unlocked) in the same cycle as the break. From then on `rd_data` equals `fl_data`.
- R6: If any byte differs, whether the first or the last, `status` becomes 8'h01 (bit 0 = failed, bit 6 = 0) in the same cycle as the break. `rd_data` stays at `BAD`.
- R7: A `fetch` strobe while `status[6]` is 0 makes `illegal_rst` pulse for one cycle in the next cycle. While the block is unlocked, `illegal_rst` stays 0.
- R8: The warm reset `rst_n` does not change `status` or the handshake progress. After a failed attempt, further received bytes produce no echo and no break until a power-on reset.
- R9: A power-on reset clears `status` to 8'h00, gates reads again and restarts the eight-byte handshake.
- R10: `erase` sets all eight stored code bytes to 8'hFF. This value persists across power-on reset.
- R11: The n-th received byte (n = 0..7) is compared with `SEC_CODE[8n+7:8n]`, so the order of the bytes matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| bit_tick | input | 1 | One-cycle strobe once per serial bit time |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Echo transmit strobe |
| tx_data | output | 8 | Echo byte |
| tx_break | output | 1 | Break request strobe |
| erase | input | 1 | Mass-erase command for the stored code |
| fetch | input | 1 | Instruction fetch from protected memory |
| fl_data | input | 8 | Raw protected-memory read data |
| rd_data | output | 8 | Gated read data |
| illegal_rst | output | 1 | Illegal-address reset request |
| status | output | 8 | Bit 6 unlocked, bit 0 failed, other bits 0 |

## Verification
The handshake is run with the correct code, with only the last byte wrong, and with the correct bytes in reverse order. These three runs show that the decision waits for all eight bytes, that a late mismatch is not lost, and that position matters as well as value. A run with a stray byte injected while an echo is pending, and another with a tick arriving together with the receive strobe, show whether the tick counter and the byte index advance only on the correct events. A run of eight 0xFF bytes before and after a mass erase, with a power-on reset in between, shows both that the erase takes effect and that it persists.

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter int NBYTES = 8,
  parameter logic [NBYTES*8-1:0] SEC_CODE = 64'h8877_6655_4433_2211,
  parameter int ECHO_TICKS = 2,
  parameter int GAP_TICKS = 1,
  parameter logic [7:0] BAD = 8'h5A
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_break,
  input  logic       erase,
  input  logic       fetch,
  input  logic [7:0] fl_data,
  output logic [7:0] rd_data,
  output logic       illegal_rst,
  output logic [7:0] status
);
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int TMAX = (ECHO_TICKS > GAP_TICKS) ? ECHO_TICKS : GAP_TICKS;
  localparam int CW = (TMAX > 1) ? $clog2(TMAX) : 1;

  typedef enum logic [1:0] {P_RX, P_ECHO, P_GAP, P_DONE} phase_t;

  phase_t              phase;
  logic [IW-1:0]       idx;
  logic [CW-1:0]       cnt;
  logic                miss, unl, fail;
  logic [7:0]          held;
  logic [NBYTES*8-1:0] code_q = SEC_CODE;

  always_ff @(posedge clk)
    if (erase) code_q <= '1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase       <= P_RX;
      idx         <= '0;
      cnt         <= '0;
      miss        <= 1'b0;
      unl         <= 1'b0;
      fail        <= 1'b0;
      held        <= '0;
      tx_valid    <= 1'b0;
      tx_break    <= 1'b0;
      illegal_rst <= 1'b0;
    end else begin
      tx_valid    <= 1'b0;
      tx_break    <= 1'b0;
      illegal_rst <= rst_n & fetch & ~unl;
      if (!rst_n) begin
        cnt <= '0;
      end else begin
        case (phase)
          P_RX: if (rx_valid) begin
            held  <= rx_data;
            miss  <= miss | (rx_data != code_q[8*idx +: 8]);
            cnt   <= '0;
            phase <= P_ECHO;
          end
          P_ECHO: if (bit_tick) begin
            if (cnt == CW'(ECHO_TICKS - 1)) begin
              tx_valid <= 1'b1;
              cnt      <= '0;
              if (idx == IW'(NBYTES - 1)) phase <= P_GAP;
              else begin
                idx   <= idx + 1'b1;
                phase <= P_RX;
              end
            end else cnt <= cnt + 1'b1;
          end
          P_GAP: if (bit_tick) begin
            if (cnt == CW'(GAP_TICKS - 1)) begin
              tx_break <= 1'b1;
              unl      <= ~miss;
              fail     <= miss;
              phase    <= P_DONE;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_data = held;
  assign rd_data = unl ? fl_data : BAD;
  assign status  = {1'b0, unl, 5'b0, fail};
endmodule

// File: rtl/sec_gate_chk.sv
module sec_gate_chk #(
  parameter logic [7:0] BAD = 8'h5A
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       fetch,
  input logic [7:0] fl_data,
  input logic [7:0] rd_data,
  input logic       tx_valid,
  input logic       tx_break,
  input logic       illegal_rst,
  input logic [7:0] status
);
  AST_ECHO_PULSE: assert property (@(posedge clk) disable iff (!por_n) tx_valid |=> !tx_valid); // R2
  AST_BREAK_PULSE: assert property (@(posedge clk) disable iff (!por_n) tx_break |=> !tx_break); // R4
  AST_BREAK_ALONE: assert property (@(posedge clk) disable iff (!por_n) !(tx_valid && tx_break)); // R4
  AST_OPEN_READ: assert property (@(posedge clk) disable iff (!por_n) status[6] |-> rd_data == fl_data); // R5
  AST_GATED_READ: assert property (@(posedge clk) disable iff (!por_n) !status[6] |-> rd_data == BAD); // R6
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!por_n) !(status[6] && status[0])); // R6
  AST_ILLEGAL_FETCH: assert property (@(posedge clk) disable iff (!por_n) (fetch && rst_n && !status[6]) |=> illegal_rst); // R7
  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n) status[6] |=> status[6]); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!por_n) status[0] |=> status[0]); // R8
endmodule

bind sec_gate sec_gate_chk #(.BAD(BAD)) u_chk (.*);

// File: tb/sim_sec_gate.sv
`timescale 1ns/1ps
module sim_sec_gate;
  localparam logic [63:0] CODE = 64'h8877_6655_4433_2211;
  localparam logic [7:0]  BADV = 8'h5A;

  logic clk = 0, por_n = 0, rst_n = 1, bit_tick = 0, rx_valid = 0, erase = 0, fetch = 0;
  logic [7:0] rx_data = 0, fl_data = 8'hC3;
  logic tx_valid, tx_break, illegal_rst;
  logic [7:0] tx_data, rd_data, status;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sec_gate #(.SEC_CODE(CODE), .BAD(BADV)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
  endtask

  task automatic do_por();
    @(negedge clk) por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit tick_with_rx, input bit stray, input bit expect_echo);
    @(negedge clk) begin rx_valid = 1; rx_data = b; bit_tick = tick_with_rx; end
    @(negedge clk) begin rx_valid = 0; bit_tick = 0; end
    tick();
    check(tx_valid == 0, "R2 early echo", tx_valid, 0);
    if (stray) begin
      @(negedge clk) begin rx_valid = 1; rx_data = ~b; end
      @(negedge clk) rx_valid = 0;
    end
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
    check(tx_valid == expect_echo, "R2 echo strobe", tx_valid, expect_echo);
    if (expect_echo) check(tx_data == b, stray ? "R3 echo data" : "R2 echo data", tx_data, b);
    @(negedge clk);
    check(tx_valid == 0, "R2 echo pulse width", tx_valid, 0);
  endtask

  task automatic run_seq(input logic [63:0] bytes, input logic [7:0] exp_status, input int stray_at, input string req);
    for (int i = 0; i < 8; i++)
      send_byte(bytes[8*i +: 8], i == 0, i == stray_at, 1'b1);
    check(tx_break == 0 && status == 8'h00, "R4 no break before gap tick", tx_break, 0);
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
    check(tx_break == 1, "R4 break after gap", tx_break, 1);
    check(status == exp_status, req, status, exp_status);
    @(negedge clk);
    check(tx_break == 0, "R4 break pulse width", tx_break, 0);
  endtask

  task automatic do_fetch(input logic exp, input string req);
    @(negedge clk) fetch = 1;
    @(negedge clk) fetch = 0;
    check(illegal_rst == exp, req, illegal_rst, exp);
    @(negedge clk);
    check(illegal_rst == 0, "R7 illegal pulse width", illegal_rst, 0);
  endtask

  task automatic t_reset();
    do_por();
    check(status == 8'h00, "R1 status", status, 0);
    check(!tx_valid && !tx_break && !illegal_rst, "R1 strobes", {tx_valid, tx_break, illegal_rst}, 0);
    check(rd_data == BADV, "R1 gated read", rd_data, BADV);
  endtask

  task automatic t_match();
    do_por();
    run_seq(CODE, 8'h40, 3, "R5 unlock status");
    check(rd_data == fl_data, "R5 open read", rd_data, fl_data);
    do_fetch(1'b0, "R7 no illegal when unlocked");
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    check(status == 8'h40, "R8 warm reset keeps unlock", status, 8'h40);
    do_por();
    check(status == 8'h00 && rd_data == BADV, "R9 por relocks", status, 0);
  endtask

  task automatic t_bad_last();
    do_por();
    run_seq({8'h00, CODE[55:0]}, 8'h01, -1, "R6 last byte wrong");
    check(rd_data == BADV, "R6 gated read", rd_data, BADV);
    do_fetch(1'b1, "R7 illegal fetch");
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    check(status == 8'h01, "R8 warm reset keeps fail", status, 8'h01);
    send_byte(CODE[7:0], 1'b0, 1'b0, 1'b0);
    tick();
    check(tx_break == 0 && status == 8'h01, "R8 no retry", status, 8'h01);
  endtask

  task automatic t_order();
    logic [63:0] rev;
    for (int i = 0; i < 8; i++) rev[8*i +: 8] = CODE[8*(7-i) +: 8];
    do_por();
    run_seq(rev, 8'h01, -1, "R11 reversed order fails");
    do_por();
    run_seq(CODE, 8'h40, -1, "R11 in-order unlock");
  endtask

  task automatic t_erase();
    do_por();
    run_seq({8{8'hFF}}, 8'h01, -1, "R10 blanks fail before erase");
    @(negedge clk) erase = 1;
    @(negedge clk) erase = 0;
    do_por();
    run_seq({8{8'hFF}}, 8'h40, -1, "R10 blanks unlock after erase");
    do_por();
    run_seq(CODE, 8'h01, -1, "R10 old code rejected after erase");
  endtask

  initial begin
    t_reset();
    t_match();
    t_bad_last();
    t_order();
    t_erase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule